// File: doc/BRIEF.md
# Linear Photodiode Array Readout Sequencer

This block is the control logic of a linear light-sensor array with 128 active photodiodes. A single-bit start input and a clock drive it. When the start input is seen high on a rising clock edge, a start token is launched into a chain of 132 stages. As the token moves one stage per clock, it selects one output slot at a time through a one-hot select bus. The slots come in a fixed order: two dummy slots, then the 128 real pixels, then two more dummy slots.

During readout the sample-and-hold capacitors are disconnected from their integrators, the integrators are held in reset, and the output driver is enabled. Once the token leaves the last stage, the output driver is released to high impedance and the integrators are freed. Light integration then runs until the next start pulse, which opens the next readout. The block also reports the current slot number, a tag that marks real-pixel slots, an integrating flag, and a one-cycle overrun pulse when a start arrives before the current readout has ended.

Top module: `linscan_sequencer`

## Requirements
- R1: After reset, the select bus is all zero, the output enable is low, the integrator reset is high, the sample-hold disconnect is low, the integrating flag is low and the overrun pulse is low.
- R2: When start is sampled high on a rising edge, the outputs after that edge show select bit 0 set, slot index 0, output enable high, sample-hold disconnect high and integrator reset high.
- R3: While a readout runs, the select bus has exactly one bit set. That bit moves up by one position on each clock, and the binary slot index always equals the position of the set bit.
- R4: The real-pixel tag is high exactly for slot indices 2 through 129 inclusive. It is low for the dummy slots 0, 1, 130 and 131 and whenever no readout runs.
- R5: Without a new start, the output enable stays high for exactly 132 consecutive cycles. It then goes low, which models the output going to high impedance, and the select bus returns to all zero.
- R6: In the cycle after slot 131, the integrator reset goes low, the sample-hold disconnect goes low and the integrating flag goes high.
- R7: Integration holds until start is sampled high again. The outputs after that edge show the integrating flag low and the integrator reset high.
- R8: A start sampled high while the output enable is high restarts the token at slot 0. It raises the overrun output for exactly one cycle, namely the cycle after that edge.
- R9: While integrating, start held low has no effect: the integrating flag stays high and the select bus stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Serial start input, sampled on the rising edge |
| sel_o | output | 132 | One-hot slot select, bit n connects slot n to the output |
| slot_idx_o | output | 8 | Binary number of the current slot, 0..131 |
| real_pix_o | output | 1 | High when the current slot holds a real pixel |
| out_en_o | output | 1 | Analog output driver enable, low means high impedance |
| integ_rst_o | output | 1 | Integrator reset |
| sh_open_o | output | 1 | Sample-hold capacitors disconnected from integrators |
| integrating_o | output | 1 | Light integration in progress |
| overrun_o | output | 1 | One-cycle pulse on a start that cuts a readout short |

## Verification
A corrupted token chain or slot counter shows at the ports within one clock. The select bit and the slot index disagree at once, and a lost or doubled token makes the output enable end one or more cycles away from the 132nd cycle after the start. An error in the phase state shows as the integrator reset or the integrating flag taking the wrong value in the first cycle after the last slot, or in the first cycle after a start. A wrong overrun decision shows as a missing or stretched pulse in the cycle after a restart.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_INTEG = 2'd2
    } phase_t;

endpackage

// File: rtl/lsq_token_chain.sv
module lsq_token_chain #(
    parameter int SLOTS = 132
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic [SLOTS-1:0] sel_o,
    output logic             last_o
);

    typedef struct packed {
        logic [SLOTS-1:0] sel;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d.sel[0] = start_i;
        for (int i = 1; i < SLOTS; i++) begin
            st_d.sel[i] = !start_i && st_q.sel[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o  = st_q.sel;
    assign last_o = st_q.sel[SLOTS-1];

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_q.sel)); // R3

    AST_TOKEN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && st_q.sel[0]) |=> st_q.sel[1]); // R3

endmodule

// File: rtl/lsq_slot_count.sv
module lsq_slot_count #(
    parameter int SLOTS = 132,
    parameter int LEAD  = 2,
    parameter int TRAIL = 2,
    parameter int IDXW  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    output logic [IDXW-1:0] idx_o,
    output logic            real_o
);

    localparam logic [IDXW-1:0] LAST_IDX  = IDXW'(SLOTS - 1);
    localparam logic [IDXW-1:0] FIRST_REAL = IDXW'(LEAD);
    localparam logic [IDXW-1:0] LAST_REAL  = IDXW'(SLOTS - TRAIL - 1);

    typedef struct packed {
        logic [IDXW-1:0] idx;
        logic            act;
        logic            real_pix;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.idx = '0;
            st_d.act = 1'b1;
        end else if (st_q.act) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.idx = '0;
                st_d.act = 1'b0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
        st_d.real_pix = st_d.act && (st_d.idx >= FIRST_REAL) && (st_d.idx <= LAST_REAL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign idx_o  = st_q.idx;
    assign real_o = st_q.real_pix;

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.idx <= LAST_IDX); // R3

    AST_REAL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.real_pix |-> st_q.act); // R4

endmodule

// File: rtl/linscan_sequencer.sv
module linscan_sequencer #(
    parameter int LEAD_SLOTS  = 2,
    parameter int REAL_SLOTS  = 128,
    parameter int TRAIL_SLOTS = 2
) (
    input  logic                                             clk,
    input  logic                                             rst_n,
    input  logic                                             start_i,
    output logic [LEAD_SLOTS+REAL_SLOTS+TRAIL_SLOTS-1:0]     sel_o,
    output logic [$clog2(LEAD_SLOTS+REAL_SLOTS+TRAIL_SLOTS)-1:0] slot_idx_o,
    output logic                                             real_pix_o,
    output logic                                             out_en_o,
    output logic                                             integ_rst_o,
    output logic                                             sh_open_o,
    output logic                                             integrating_o,
    output logic                                             overrun_o
);
    import lsq_pkg::*;

    localparam int SLOTS = LEAD_SLOTS + REAL_SLOTS + TRAIL_SLOTS;
    localparam int IDXW  = $clog2(SLOTS);

    typedef struct packed {
        phase_t phase;
        logic   ovr;
    } ctl_t;

    ctl_t st_d, st_q;
    logic last_w;

    lsq_token_chain #(.SLOTS(SLOTS)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sel_o   (sel_o),
        .last_o  (last_w)
    );

    lsq_slot_count #(
        .SLOTS (SLOTS),
        .LEAD  (LEAD_SLOTS),
        .TRAIL (TRAIL_SLOTS),
        .IDXW  (IDXW)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .idx_o   (slot_idx_o),
        .real_o  (real_pix_o)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ovr = start_i && (st_q.phase == PH_READ);
        if (start_i)                              st_d.phase = PH_READ;
        else if (st_q.phase == PH_READ && last_w) st_d.phase = PH_INTEG;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.ovr   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_en_o      = (st_q.phase == PH_READ);
    assign sh_open_o     = (st_q.phase == PH_READ);
    assign integ_rst_o   = (st_q.phase != PH_INTEG);
    assign integrating_o = (st_q.phase == PH_INTEG);
    assign overrun_o     = st_q.ovr;

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sel_o[0] && out_en_o && integ_rst_o)); // R2

    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_o |-> sel_o[slot_idx_o]); // R3

    AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_o |-> (sel_o == '0)); // R5

    AST_END_INTEG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en_o && slot_idx_o == IDXW'(SLOTS-1) && !start_i)
            |=> (integrating_o && !integ_rst_o && !out_en_o)); // R6

    AST_OVR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && out_en_o) |=> overrun_o); // R8

    AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (integrating_o && !start_i) |=> integrating_o); // R9

endmodule

// File: tb/sim_linscan_sequencer.sv
module sim_linscan_sequencer;

    localparam int SLOTS = 132;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [SLOTS-1:0] sel_o;
    logic [7:0]       slot_idx_o;
    logic             real_pix_o, out_en_o, integ_rst_o, sh_open_o;
    logic             integrating_o, overrun_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    linscan_sequencer u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .sel_o(sel_o), .slot_idx_o(slot_idx_o), .real_pix_o(real_pix_o),
        .out_en_o(out_en_o), .integ_rst_o(integ_rst_o), .sh_open_o(sh_open_o),
        .integrating_o(integrating_o), .overrun_o(overrun_o)
    );

    task automatic chk(input string tag, input logic [SLOTS-1:0] act, input logic [SLOTS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [SLOTS-1:0] bit_at(input int n);
        logic [SLOTS-1:0] one = 1;
        return one << n;
    endfunction

    task automatic t_reset();
        chk("R1 sel", sel_o, '0);
        chk("R1 out_en", SLOTS'(out_en_o), '0);
        chk("R1 integ_rst", SLOTS'(integ_rst_o), 1);
        chk("R1 sh_open", SLOTS'(sh_open_o), '0);
        chk("R1 integrating", SLOTS'(integrating_o), '0);
        chk("R1 overrun", SLOTS'(overrun_o), '0);
    endtask

    task automatic walk_slots(input int from);
        for (int n = from; n < SLOTS; n++) begin
            chk("R3 sel", sel_o, bit_at(n));
            chk("R3 idx", SLOTS'(slot_idx_o), SLOTS'(n));
            chk("R4 real", SLOTS'(real_pix_o), SLOTS'((n >= 2) && (n <= 129)));
            chk("R5 out_en", SLOTS'(out_en_o), 1);
            chk("R2 integ_rst", SLOTS'(integ_rst_o), 1);
            chk("R2 sh_open", SLOTS'(sh_open_o), 1);
            tick();
        end
        chk("R5 out_en off", SLOTS'(out_en_o), '0);
        chk("R5 sel clear", sel_o, '0);
        chk("R4 real off", SLOTS'(real_pix_o), '0);
        chk("R6 integ_rst", SLOTS'(integ_rst_o), '0);
        chk("R6 sh_open", SLOTS'(sh_open_o), '0);
        chk("R6 integrating", SLOTS'(integrating_o), 1);
    endtask

    task automatic t_full_frame();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk("R2 sel0", sel_o, bit_at(0));
        chk("R2 idx0", SLOTS'(slot_idx_o), '0);
        chk("R2 overrun", SLOTS'(overrun_o), '0);
        walk_slots(0);
    endtask

    task automatic t_integ_hold();
        for (int k = 0; k < 20; k++) tick();
        chk("R9 integrating", SLOTS'(integrating_o), 1);
        chk("R9 sel", sel_o, '0);
        chk("R9 out_en", SLOTS'(out_en_o), '0);
    endtask

    task automatic t_restart();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk("R7 integrating", SLOTS'(integrating_o), '0);
        chk("R7 integ_rst", SLOTS'(integ_rst_o), 1);
        for (int k = 0; k < 9; k++) tick();
        chk("R3 idx9", SLOTS'(slot_idx_o), SLOTS'(9));
        chk("R8 no overrun yet", SLOTS'(overrun_o), '0);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        chk("R8 overrun", SLOTS'(overrun_o), 1);
        chk("R8 sel0", sel_o, bit_at(0));
        chk("R8 idx0", SLOTS'(slot_idx_o), '0);
        tick();
        chk("R8 overrun one cycle", SLOTS'(overrun_o), '0);
        walk_slots(1);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        #10;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_full_frame();
        t_integ_hold();
        t_restart();
        t_full_frame();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule